// File: doc/BRIEF.md
# VSYNC-Clocked Display Identification Serial Transmitter

This block sends display identification bytes on a single serial data line. The line is clocked by the monitor's vertical sync input. A two-flop synchroniser brings VSYNC into the system clock domain, and an edge detector finds each rising edge there. Each rising edge advances the serial line by one bit. Every byte goes out as a 9-bit packet: eight data bits, most significant first, then one separator bit that is always 1. The data pin is open-drain. The block pulls it low for a 0 and releases it for a 1.

Software keeps an 8-entry transmit FIFO filled through a CPU write strobe. A low-level flag tells software to refill the FIFO when fewer than N bytes wait in it. N is 2, 3, 4 or 5, chosen by a 2-bit select. An enable passes this flag to an interrupt output. A full flag tells software to stop writing.

An auto-load mode lets software move data with less work. In this mode, every read of the memory-buffer data register also pushes the byte that was read into the FIFO.

Top module: `ddc1_tx`

## Requirements
- R1: After reset the data line is released (`sda_oe_o`=0), `fifo_low_o`=1, `fifo_full_o`=0 and `irq_o`=0.
- R2: The FIFO holds 8 bytes. `fifo_full_o` is 1 exactly when 8 bytes are waiting, and bytes leave the FIFO in the order they were written.
- R3: A push while `fifo_full_o`=1 is ignored. The byte is never sent, and no earlier byte is lost.
- R4: Each byte goes out as a 9-bit packet: bit 7 first, down to bit 0, then a separator bit of 1. The line takes one new bit per rising edge of VSYNC, 2 to 3 clocks after that edge.
- R5: When a packet would start and the FIFO is empty, the line stays released. Nothing is sent until a byte arrives, and no filler byte is sent.
- R6: `fifo_low_o` is 1 when the number of waiting bytes is below N. N comes from `lvl_sel_i`: 00 gives 2, 01 gives 3, 10 gives 4, 11 gives 5. A byte counts as sent once its packet has begun.
- R7: `irq_o` equals `fifo_low_o` when `low_ie_i`=1, and is 0 when `low_ie_i`=0.
- R8: When `autoload_i`=1, a `mbuf_rd_i` strobe pushes `mbuf_data_i` into the FIFO. When `autoload_i`=0, the strobe has no effect.
- R9: If `cpu_wr_i` and an auto-load push fall in the same cycle, only `cpu_wdata_i` is stored.
- R10: `sda_oe_o` is 1 only while a 0 bit is on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsync_i | input | 1 | Vertical sync input, used as the bit clock (asynchronous) |
| cpu_wr_i | input | 1 | CPU write strobe into the FIFO |
| cpu_wdata_i | input | 8 | CPU write data |
| mbuf_rd_i | input | 1 | Strobe for a memory-buffer data read |
| mbuf_data_i | input | 8 | Byte returned by that read |
| autoload_i | input | 1 | Auto-load mode enable |
| lvl_sel_i | input | 2 | Low-level threshold select |
| low_ie_i | input | 1 | Low-level interrupt enable |
| sda_oe_o | output | 1 | Pull-down enable for the open-drain data line |
| fifo_low_o | output | 1 | FIFO low-level flag |
| fifo_full_o | output | 1 | FIFO full flag |
| irq_o | output | 1 | Masked low-level interrupt |

## Verification
The bench fills the FIFO past 8 bytes. A design that stored the extra byte would send a ninth packet, and one that wrapped its pointers would corrupt an earlier packet. The bench drains the FIFO into empty time, where a design that sent an underflow byte would drive zeros. The bench checks all four threshold codes at every fill level, and an off-by-one compare would show at the edge of each threshold. It also issues buffer reads with auto-load off, and collisions where a CPU write and an auto-load push land in the same cycle. A leaky mode bit or the wrong priority would then put unexpected bytes on the line.

// File: rtl/ddc1_pkg.sv
package ddc1_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned LVL_SEL_W = 2;
  localparam int unsigned LVL_BASE  = 2;  // sel 0 -> threshold 2
endpackage

// File: rtl/ddc1_sync.sv
module ddc1_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= async_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= chain_q[STAGES-1];

  assign rise_o = chain_q[STAGES-1] & ~prev_q;

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ddc1_fifo.sv
module ddc1_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CW-1:0]     count_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_q, rd_q;
  logic [CW-1:0]     count_q;
  logic              do_push, do_pop;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i & ~full_o;  // writes while full are dropped
  assign do_pop  = pop_i & ~empty_o;
  assign rdata_o = mem_q[rd_q];
  assign count_o = count_q;

  function automatic logic [AW-1:0] inc_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
    end else begin
      if (do_push) wr_q <= inc_ptr(wr_q);
      if (do_pop)  rd_q <= inc_ptr(rd_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i)
    if (do_push) mem_q[wr_q] <= wdata_i;

  a_r3_full_push_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (count_q == $past(count_q)));
  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  a_r5_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/ddc1_shifter.sv
module ddc1_shifter #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IW    = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              avail_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              pop_o,
  output logic              sda_o
);
  logic              busy_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] sh_q;
  logic              sda_q;

  assign pop_o = tick_i & ~busy_q & avail_i;
  assign sda_o = sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      sh_q   <= '0;
      sda_q  <= 1'b1;
    end else if (tick_i) begin
      if (!busy_q) begin
        if (avail_i) begin
          sda_q  <= data_i[DATA_W-1];
          sh_q   <= data_i << 1;
          idx_q  <= IW'(1);
          busy_q <= 1'b1;
        end else begin
          sda_q  <= 1'b1;  // idle: keep line released
        end
      end else if (idx_q < IW'(DATA_W)) begin
        sda_q <= sh_q[DATA_W-1];
        sh_q  <= sh_q << 1;
        idx_q <= idx_q + 1'b1;
      end else begin
        sda_q  <= 1'b1;    // separator bit
        busy_q <= 1'b0;
        idx_q  <= '0;
      end
    end
  end

  a_r4_separator_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && busy_q && idx_q == IW'(DATA_W)) |=> sda_q);
  a_r5_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !busy_q && !avail_i) |=> sda_q);
  a_r4_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(sda_q));
endmodule

// File: rtl/ddc1_tx.sv
module ddc1_tx
  import ddc1_pkg::*;
#(
  parameter int unsigned DEPTH       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned CW         = $clog2(DEPTH + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vsync_i,
  input  logic                 cpu_wr_i,
  input  logic [BYTE_W-1:0]    cpu_wdata_i,
  input  logic                 mbuf_rd_i,
  input  logic [BYTE_W-1:0]    mbuf_data_i,
  input  logic                 autoload_i,
  input  logic [LVL_SEL_W-1:0] lvl_sel_i,
  input  logic                 low_ie_i,
  output logic                 sda_oe_o,
  output logic                 fifo_low_o,
  output logic                 fifo_full_o,
  output logic                 irq_o
);
  logic              tick, push, pop, empty, sda;
  logic [BYTE_W-1:0] push_data, head;
  logic [CW-1:0]     count;
  logic [CW:0]       thresh;

  // CPU write wins over an auto-load push in the same cycle
  assign push      = cpu_wr_i | (autoload_i & mbuf_rd_i);
  assign push_data = cpu_wr_i ? cpu_wdata_i : mbuf_data_i;

  ddc1_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .async_i(vsync_i), .rise_o(tick)
  );

  ddc1_fifo #(.DATA_W(BYTE_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .wdata_i(push_data),
    .pop_i(pop), .rdata_o(head),
    .count_o(count), .full_o(fifo_full_o), .empty_o(empty)
  );

  ddc1_shifter #(.DATA_W(BYTE_W)) u_shift (
    .clk_i, .rst_ni, .tick_i(tick), .avail_i(~empty),
    .data_i(head), .pop_o(pop), .sda_o(sda)
  );

  always_comb thresh = (CW+1)'(lvl_sel_i) + (CW+1)'(LVL_BASE);

  assign fifo_low_o = ({1'b0, count} < thresh);
  assign irq_o      = fifo_low_o & low_ie_i;
  assign sda_oe_o   = ~sda;  // open drain: pull low only for a 0

  a_r8_no_autoload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mbuf_rd_i && !autoload_i && !cpu_wr_i && !pop) |=> (count == $past(count)));
  a_r8_autoload_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mbuf_rd_i && autoload_i && !fifo_full_o && !pop) |=> (count == $past(count) + 1'b1));
endmodule

// File: tb/ddc1_tx_tb.sv
module ddc1_tx_tb;
  logic       clk = 0, rst_n = 0;
  logic       vsync = 0, cpu_wr = 0, mbuf_rd = 0, autoload = 0, low_ie = 0;
  logic [7:0] cpu_wdata = 0, mbuf_data = 0;
  logic [1:0] lvl_sel = 0;
  logic       sda_oe, fifo_low, fifo_full, irq;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [7:0] mq[$];
  bit         m_busy = 0;
  logic [7:0] m_sh = 0;
  int         m_idx = 0;
  bit         m_bit = 1;

  always #2 clk = ~clk;  // 250 MHz

  ddc1_tx u_dut (
    .clk_i(clk), .rst_ni(rst_n), .vsync_i(vsync),
    .cpu_wr_i(cpu_wr), .cpu_wdata_i(cpu_wdata),
    .mbuf_rd_i(mbuf_rd), .mbuf_data_i(mbuf_data),
    .autoload_i(autoload), .lvl_sel_i(lvl_sel), .low_ie_i(low_ie),
    .sda_oe_o(sda_oe), .fifo_low_o(fifo_low), .fifo_full_o(fifo_full), .irq_o(irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_low();
    return mq.size() < (int'(lvl_sel) + 2);
  endfunction

  task automatic check_flags();
    chk("R6 low", fifo_low, exp_low());
    chk("R2 full", fifo_full, mq.size() == 8);
    chk("R7 irq", irq, exp_low() & low_ie);
  endtask

  task automatic model_push(input logic [7:0] b);
    if (mq.size() < 8) mq.push_back(b);
  endtask

  task automatic cpu_write(input logic [7:0] b);
    @(negedge clk); cpu_wr = 1; cpu_wdata = b;
    @(negedge clk); cpu_wr = 0;
    model_push(b);
  endtask

  task automatic mbuf_read(input logic [7:0] b, input bit with_wr, input logic [7:0] wb);
    @(negedge clk); mbuf_rd = 1; mbuf_data = b; cpu_wr = with_wr; cpu_wdata = wb;
    @(negedge clk); mbuf_rd = 0; cpu_wr = 0;
    if (with_wr) model_push(wb);           // R9
    else if (autoload) model_push(b);      // R8
  endtask

  task automatic pulse();
    @(negedge clk); vsync = 1;
    repeat (4) @(negedge clk);
    vsync = 0;
    repeat (4) @(negedge clk);
    if (!m_busy) begin
      if (mq.size() > 0) begin
        m_sh = mq.pop_front(); m_bit = m_sh[7]; m_idx = 1; m_busy = 1;
      end else m_bit = 1;
    end else if (m_idx < 8) begin
      m_bit = m_sh[7 - m_idx]; m_idx++;
    end else begin
      m_bit = 1; m_busy = 0; m_idx = 0;
    end
    chk("R4/R10 sda", sda_oe, !m_bit);
  endtask

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 oe", sda_oe, 0); chk("R1 low", fifo_low, 1);
    chk("R1 full", fifo_full, 0); chk("R1 irq", irq, 0);
    rst_n = 1;
    @(negedge clk);
    low_ie = 1;
    // R2/R6 fill to full, every threshold code at every level
    for (int i = 0; i < 8; i++) begin
      cpu_write(8'hA0 + 8'(i));
      for (int s = 0; s < 4; s++) begin
        lvl_sel = 2'(s); #1; check_flags();
      end
    end
    // R3 writes while full are dropped
    cpu_write(8'h00); cpu_write(8'h00); check_flags();
    low_ie = 0; #1; check_flags();   // R7 masked
    // R4 drain, then R5 idle line
    for (int i = 0; i < 8 * 9 + 12; i++) begin
      pulse();
      if (i % 9 == 0) check_flags();
    end
    // R8 auto-load off: no effect
    autoload = 0;
    mbuf_read(8'h00, 0, 8'h00); mbuf_read(8'h00, 0, 8'h00); check_flags();
    for (int i = 0; i < 10; i++) pulse();
    // R8 auto-load on, R9 collision
    autoload = 1; low_ie = 1;
    mbuf_read(8'h3C, 0, 8'h00);
    mbuf_read(8'h00, 1, 8'hC5);
    check_flags();
    for (int i = 0; i < 20; i++) pulse();
    // random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      lvl_sel = 2'($urandom_range(0, 3));
      low_ie  = 1'($urandom_range(0, 1));
      autoload = 1'($urandom_range(0, 1));
      if (op < 3) cpu_write(8'($urandom));
      else if (op < 5) mbuf_read(8'($urandom), 1'($urandom_range(0, 1)), 8'($urandom));
      else pulse();
      #1; check_flags();
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule